// File: doc/BRIEF.md
# Port Jabber and Partition Guard

This block watches every port of a multi-port repeater and decides, per port, whether that port must be silenced. Two independent mechanisms run side by side. A carrier-run timer cuts a port off when its carrier sense has stayed high for too long, and it releases the port as soon as the line goes quiet. A consecutive-collision tally isolates (partitions) the receive side of a port that keeps colliding. The port is only let back in once a collision-free packet of at least minimum frame length has been sent out of it.

The repeater core feeds the block per-port carrier sense, a per-port collision flag, per-port transmit enable and a one-cycle end-of-packet strobe. Two static controls select the partition threshold and switch auto-partition off. The block returns a cutoff flag and a partition flag for each port. It also drives a six-bit status bus that scans through the ports so that an external decoder can light LEDs.

Top module: `port_guard`

## Requirements
- R1: A port's `cutoff` bit goes to 1 after the clock edge that samples `crs` high for the JAB_LIMIT-th consecutive cycle (16384 by default, which is 655 µs at 25 MHz). A run of JAB_LIMIT-1 high samples followed by a low sample leaves it at 0.
- R2: While set, `cutoff` stays 1 as long as `crs` stays high. It returns to 0 after the first edge that samples `crs` low.
- R3: Each port's cutoff and partition state depends only on that port's own inputs. A jabbering port leaves every other port's flags unchanged.
- R4: A packet ends on the cycle where `eop` is high. It counts as collided if `colFlag` was high on any cycle after the previous `eop` of that port, up to and including this one. With `selLong`=0, `partitioned` goes to 1 after the `eop` of the 32nd consecutive collided packet, and not after the 31st.
- R5: With `selLong`=1 the threshold is 64 consecutive collided packets: after 63 the flag stays 0, and after the 64th it goes to 1.
- R6: A packet without collision resets the consecutive count to zero, whatever its length.
- R7: A partitioned port is reconnected (`partitioned` to 0) by the `eop` of a collision-free packet during which `txEn` was high for at least 128 cycles, counting the `eop` cycle. That is 512 bits of nibble data. A clean packet of 127 such cycles leaves it partitioned.
- R8: While `partDisable` is 1, every `partitioned` bit is 0 from the next cycle on and the collision counts are held at zero. After the control is released, counting starts again from zero.
- R9: `ledBus[3:0]` holds a port number that starts at 0 after reset and advances by one every 256 clocks. After port NUM_PORTS-1 it wraps back to 0.
- R10: `ledBus[4]` is the partition flag and `ledBus[5]` is the cutoff flag of the port shown in `ledBus[3:0]`, with 1 meaning active.
- R11: During reset all cutoff and partition flags are 0 and `ledBus` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Active-low synchronous reset |
| crs | input | NUM_PORTS | Per-port carrier sense |
| colFlag | input | NUM_PORTS | Per-port collision indication |
| txEn | input | NUM_PORTS | Per-port transmit enable, one nibble per cycle |
| eop | input | NUM_PORTS | Per-port end-of-packet strobe |
| selLong | input | 1 | 0: partition after 32 collisions, 1: after 64 |
| partDisable | input | 1 | Turns auto-partition off |
| cutoff | output | NUM_PORTS | Per-port jabber cutoff |
| partitioned | output | NUM_PORTS | Per-port partition state |
| ledBus | output | 6 | {cutoff, partition, port number} of the scanned port |

## Verification
Every flag is a single register stage behind its inputs. A jabber cutoff is therefore due right after the edge that takes the JAB_LIMIT-th high carrier sample, and a release right after the first low sample. A partition change is due on the edge that samples `eop`, and the disable takes effect on the first edge after it is raised. The scoreboard stamps each expected value with the absolute cycle on which it is due. It compares one nanosecond after that rising edge, so the cycles just before and just after each threshold are both checked. The LED expectations are computed from the number of edges since reset was released, and they are sampled across more than one full scan so that the wrap is seen.

// File: rtl/portguard_pkg.sv
package portguard_pkg;

  // Per-port counter commands issued by the control to the datapath.
  typedef struct packed {
    logic runInc;   // advance the carrier-run timer
    logic runClr;   // carrier idle: restart the run timer
    logic colInc;   // one more consecutive collided packet
    logic colClr;   // clean packet or auto-partition off
    logic lenInc;   // one more transmitted nibble
    logic lenClr;   // packet boundary
  } guardStrobe_t;

endpackage

// File: rtl/guard_datapath.sv
module guard_datapath
  import portguard_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int JAB_LIMIT     = 16384,
  parameter int LONG_RUN      = 64,
  parameter int MIN_TX_CYCLES = 128,
  parameter int RUN_W         = 14,
  parameter int COL_W         = 7,
  parameter int LEN_W         = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  guardStrobe_t         strobe  [NUM_PORTS],
  output logic [NUM_PORTS-1:0] runLast,
  output logic [NUM_PORTS-1:0] colFull,
  output logic [NUM_PORTS-1:0] lenFull,
  output logic [COL_W-1:0]     colCnt  [NUM_PORTS],
  output logic [LEN_W-1:0]     lenCnt  [NUM_PORTS]
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
    logic [RUN_W-1:0] runCnt;
    logic [COL_W-1:0] colReg;
    logic [LEN_W-1:0] lenReg;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        runCnt <= '0;
      end else if (strobe[p].runClr) begin
        runCnt <= '0;
      end else if (strobe[p].runInc) begin
        runCnt <= runCnt + RUN_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        colReg <= '0;
      end else if (strobe[p].colClr) begin
        colReg <= '0;
      end else if (strobe[p].colInc) begin
        colReg <= colReg + COL_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lenReg <= '0;
      end else if (strobe[p].lenClr) begin
        lenReg <= '0;
      end else if (strobe[p].lenInc) begin
        lenReg <= lenReg + LEN_W'(1);
      end
    end

    assign runLast[p] = (runCnt == RUN_W'(JAB_LIMIT - 1));
    assign colFull[p] = (colReg == COL_W'(LONG_RUN));
    assign lenFull[p] = (lenReg == LEN_W'(MIN_TX_CYCLES));
    assign colCnt[p]  = colReg;
    assign lenCnt[p]  = lenReg;
  end

endmodule

// File: rtl/guard_ctrl.sv
module guard_ctrl
  import portguard_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int SHORT_RUN     = 32,
  parameter int LONG_RUN      = 64,
  parameter int MIN_TX_CYCLES = 128,
  parameter int LED_DWELL     = 256,
  parameter int COL_W         = 7,
  parameter int LEN_W         = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] crs,
  input  logic [NUM_PORTS-1:0] colFlag,
  input  logic [NUM_PORTS-1:0] txEn,
  input  logic [NUM_PORTS-1:0] eop,
  input  logic                 selLong,
  input  logic                 partDisable,
  input  logic [NUM_PORTS-1:0] runLast,
  input  logic [NUM_PORTS-1:0] colFull,
  input  logic [NUM_PORTS-1:0] lenFull,
  input  logic [COL_W-1:0]     colCnt [NUM_PORTS],
  input  logic [LEN_W-1:0]     lenCnt [NUM_PORTS],
  output guardStrobe_t         strobe [NUM_PORTS],
  output logic [NUM_PORTS-1:0] cutoff,
  output logic [NUM_PORTS-1:0] partitioned,
  output logic [5:0]           ledBus
);

  localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int DWELL_W   = (LED_DWELL > 1) ? $clog2(LED_DWELL) : 1;
  localparam int LED_IDX_W = 4;

  logic [NUM_PORTS-1:0] colSeen;
  logic [NUM_PORTS-1:0] hit;
  logic [NUM_PORTS-1:0] reachLimit;
  logic [NUM_PORTS-1:0] longEnough;
  logic [COL_W:0]       colNext  [NUM_PORTS];
  logic [LEN_W:0]       lenTotal [NUM_PORTS];
  logic [COL_W:0]       thresh;

  assign thresh = selLong ? (COL_W+1)'(LONG_RUN) : (COL_W+1)'(SHORT_RUN);

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      hit[i]        = colFlag[i] | colSeen[i];
      colNext[i]    = (COL_W+1)'(colCnt[i]) + (COL_W+1)'(1);
      lenTotal[i]   = (LEN_W+1)'(lenCnt[i]) + (LEN_W+1)'(txEn[i]);
      reachLimit[i] = (colNext[i] >= thresh);
      longEnough[i] = (lenTotal[i] >= (LEN_W+1)'(MIN_TX_CYCLES));
      strobe[i].runInc = crs[i] & ~runLast[i];
      strobe[i].runClr = ~crs[i];
      strobe[i].colInc = eop[i] & hit[i] & ~colFull[i] & ~partDisable;
      strobe[i].colClr = partDisable | (eop[i] & ~hit[i]);
      strobe[i].lenInc = txEn[i] & ~eop[i] & ~lenFull[i];
      strobe[i].lenClr = eop[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colSeen     <= '0;
      cutoff      <= '0;
      partitioned <= '0;
    end else begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        if (eop[i]) begin
          colSeen[i] <= 1'b0;
        end else if (colFlag[i]) begin
          colSeen[i] <= 1'b1;
        end

        if (!crs[i]) begin
          cutoff[i] <= 1'b0;
        end else if (runLast[i]) begin
          cutoff[i] <= 1'b1;
        end

        if (partDisable) begin
          partitioned[i] <= 1'b0;
        end else if (eop[i] && hit[i] && reachLimit[i]) begin
          partitioned[i] <= 1'b1;
        end else if (eop[i] && !hit[i] && longEnough[i]) begin
          partitioned[i] <= 1'b0;
        end
      end
    end
  end

  // Status scan for an external LED decoder.
  logic [DWELL_W-1:0] dwellCnt;
  logic [IDX_W-1:0]   scanIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dwellCnt <= '0;
      scanIdx  <= '0;
    end else if (dwellCnt == DWELL_W'(LED_DWELL - 1)) begin
      dwellCnt <= '0;
      scanIdx  <= (scanIdx == IDX_W'(NUM_PORTS - 1)) ? '0 : scanIdx + IDX_W'(1);
    end else begin
      dwellCnt <= dwellCnt + DWELL_W'(1);
    end
  end

  assign ledBus = {cutoff[scanIdx], partitioned[scanIdx], LED_IDX_W'(scanIdx)};

endmodule

// File: rtl/port_guard.sv
module port_guard
  import portguard_pkg::*;
#(
  parameter int NUM_PORTS     = 8,
  parameter int JAB_LIMIT     = 16384,
  parameter int SHORT_RUN     = 32,
  parameter int LONG_RUN      = 64,
  parameter int MIN_TX_CYCLES = 128,
  parameter int LED_DWELL     = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_PORTS-1:0] crs,
  input  logic [NUM_PORTS-1:0] colFlag,
  input  logic [NUM_PORTS-1:0] txEn,
  input  logic [NUM_PORTS-1:0] eop,
  input  logic                 selLong,
  input  logic                 partDisable,
  output logic [NUM_PORTS-1:0] cutoff,
  output logic [NUM_PORTS-1:0] partitioned,
  output logic [5:0]           ledBus
);

  localparam int RUN_W = $clog2(JAB_LIMIT);
  localparam int COL_W = $clog2(LONG_RUN + 1);
  localparam int LEN_W = $clog2(MIN_TX_CYCLES + 1);

  guardStrobe_t         strobe [NUM_PORTS];
  logic [NUM_PORTS-1:0] runLast;
  logic [NUM_PORTS-1:0] colFull;
  logic [NUM_PORTS-1:0] lenFull;
  logic [COL_W-1:0]     colCnt [NUM_PORTS];
  logic [LEN_W-1:0]     lenCnt [NUM_PORTS];

  guard_ctrl #(
    .NUM_PORTS(NUM_PORTS), .SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN),
    .MIN_TX_CYCLES(MIN_TX_CYCLES), .LED_DWELL(LED_DWELL),
    .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .crs(crs), .colFlag(colFlag), .txEn(txEn),
    .eop(eop), .selLong(selLong), .partDisable(partDisable),
    .runLast(runLast), .colFull(colFull), .lenFull(lenFull),
    .colCnt(colCnt), .lenCnt(lenCnt), .strobe(strobe),
    .cutoff(cutoff), .partitioned(partitioned), .ledBus(ledBus)
  );

  guard_datapath #(
    .NUM_PORTS(NUM_PORTS), .JAB_LIMIT(JAB_LIMIT), .LONG_RUN(LONG_RUN),
    .MIN_TX_CYCLES(MIN_TX_CYCLES), .RUN_W(RUN_W), .COL_W(COL_W), .LEN_W(LEN_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .runLast(runLast), .colFull(colFull), .lenFull(lenFull),
    .colCnt(colCnt), .lenCnt(lenCnt)
  );

endmodule

// File: rtl/port_guard_checker.sv
module port_guard_checker #(
  parameter int NUM_PORTS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_PORTS-1:0] crs,
  input logic [NUM_PORTS-1:0] colFlag,
  input logic [NUM_PORTS-1:0] eop,
  input logic                 partDisable,
  input logic [NUM_PORTS-1:0] cutoff,
  input logic [NUM_PORTS-1:0] partitioned,
  input logic [5:0]           ledBus
);

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
    p_jab_set_r1: assert property (@(posedge clk) disable iff (!rstN)
      $rose(cutoff[i]) |-> $past(crs[i]));

    p_jab_release_r2: assert property (@(posedge clk) disable iff (!rstN)
      !crs[i] |=> !cutoff[i]);

    p_part_set_r4: assert property (@(posedge clk) disable iff (!rstN)
      $rose(partitioned[i]) |-> ($past(eop[i]) && !$past(partDisable)));

    p_part_reconnect_r7: assert property (@(posedge clk) disable iff (!rstN)
      $fell(partitioned[i]) |-> ($past(partDisable) || ($past(eop[i]) && !$past(colFlag[i]))));
  end

  p_disable_r8: assert property (@(posedge clk) disable iff (!rstN)
    partDisable |=> (partitioned == '0));

  p_led_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    32'(ledBus[3:0]) < NUM_PORTS);

  p_led_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ledBus[3:0] != $past(ledBus[3:0])) |->
      (32'(ledBus[3:0]) == ((32'($past(ledBus[3:0])) + 1) % NUM_PORTS)));

endmodule

bind port_guard port_guard_checker #(.NUM_PORTS(NUM_PORTS)) u_guardChk (.*);

// File: tb/test_port_guard.sv
`timescale 1ns/1ps
module test_port_guard;
  localparam int NP   = 8;
  localparam int JL   = 16384;
  localparam int DW   = 256;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rstN;
  logic [NP-1:0] crs, colFlag, txEn, eop;
  logic          selLong, partDisable;
  logic [NP-1:0] cutoff, partitioned;
  logic [5:0]    ledBus;

  port_guard i_port_guard (
    .clk(clk), .rstN(rstN), .crs(crs), .colFlag(colFlag), .txEn(txEn),
    .eop(eop), .selLong(selLong), .partDisable(partDisable),
    .cutoff(cutoff), .partitioned(partitioned), .ledBus(ledBus)
  );

  typedef struct {
    int         due;
    int         kind;   // 0: port flags {cutoff,partitioned}, 1: LED bus
    int         port;
    logic [5:0] exp;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int compared = 0;
  int mismatched = 0;
  int relCyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares every expectation that falls due on this edge.
  always @(posedge clk) begin
    item_t it;
    logic [5:0] act;
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      it = q.pop_front();
      act = (it.kind == 0) ? {4'b0, cutoff[it.port], partitioned[it.port]} : ledBus;
      compared++;
      if (it.due < cyc || act !== it.exp) begin
        mismatched++;
        $display("FAIL %s kind %0d port %0d cycle %0d: actual %b expected %b",
                 it.req, it.kind, it.port, it.due, act, it.exp);
      end
    end
  end

  task automatic expectPort(int due, int p, logic c, logic pt, string r);
    item_t it;
    it.due = due; it.kind = 0; it.port = p; it.exp = {4'b0, c, pt}; it.req = r;
    q.push_back(it);
  endtask

  task automatic expectLed(int due, logic [5:0] e, string r);
    item_t it;
    it.due = due; it.kind = 1; it.port = 0; it.exp = e; it.req = r;
    q.push_back(it);
  endtask

  task automatic sendPkt(int p, int len, bit col);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      txEn[p]    = 1'b1;
      colFlag[p] = col && (i == len / 2);
      eop[p]     = (i == len - 1);
    end
    @(negedge clk);
    txEn[p] = 1'b0; colFlag[p] = 1'b0; eop[p] = 1'b0;
  endtask

  task automatic burst(int p, int n, bit col);
    for (int k = 0; k < n; k++) sendPkt(p, 8, col);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    int p0;
    rstN = 1'b0; crs = '0; colFlag = '0; txEn = '0; eop = '0;
    selLong = 1'b0; partDisable = 1'b0;
    repeat (4) @(negedge clk);
    // R11: reset state
    for (int i = 0; i < NP; i++) expectPort(cyc + 1, i, 1'b0, 1'b0, "R11");
    expectLed(cyc + 1, 6'd0, "R11");
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    relCyc = cyc;

    // R1/R3: jabber on port 2
    @(negedge clk);
    crs[2] = 1'b1; p0 = cyc;
    expectPort(p0 + JL - 1, 2, 1'b0, 1'b0, "R1");
    expectPort(p0 + JL, 2, 1'b1, 1'b0, "R1");
    expectPort(p0 + JL, 3, 1'b0, 1'b0, "R3");
    expectPort(p0 + JL + 2, 2, 1'b1, 1'b0, "R2");
    repeat (JL + 2) @(negedge clk);
    crs[2] = 1'b0;
    expectPort(cyc + 1, 2, 1'b0, 1'b0, "R2");
    repeat (3) @(negedge clk);

    // R1: one sample short of the limit
    crs[2] = 1'b1; p0 = cyc;
    repeat (JL - 1) @(negedge clk);
    crs[2] = 1'b0;
    expectPort(p0 + JL, 2, 1'b0, 1'b0, "R1");
    repeat (3) @(negedge clk);

    // R4: threshold 32
    burst(1, 31, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R4");
    burst(1, 1, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b1, "R4");
    expectPort(cyc + 1, 0, 1'b0, 1'b0, "R3");
    // R7: 127 clean cycles is not enough, 128 is
    sendPkt(1, 127, 1'b0);
    expectPort(cyc + 1, 1, 1'b0, 1'b1, "R7");
    sendPkt(1, 128, 1'b0);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R7");

    // R6: short clean packet restarts the run
    burst(1, 31, 1'b1);
    sendPkt(1, 10, 1'b0);
    burst(1, 31, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R6");
    burst(1, 1, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b1, "R6");
    sendPkt(1, 128, 1'b0);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R7");

    // R5: threshold 64
    selLong = 1'b1;
    burst(1, 63, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R5");
    burst(1, 1, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b1, "R5");

    // R8: disable clears and suppresses
    @(negedge clk);
    partDisable = 1'b1;
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R8");
    burst(1, 70, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R8");
    @(negedge clk);
    partDisable = 1'b0;
    burst(1, 63, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b0, "R8");

    // R9/R10: LED scan with port 1 partitioned and port 2 cut off
    selLong = 1'b0;
    burst(1, 32, 1'b1);
    expectPort(cyc + 1, 1, 1'b0, 1'b1, "R10");
    @(negedge clk);
    crs[2] = 1'b1;
    repeat (JL + 4) @(negedge clk);
    expectPort(cyc + 1, 2, 1'b1, 1'b0, "R10");
    for (int k = 1; k <= 2400; k += 37) begin
      int d;
      int idx;
      d = cyc + k;
      idx = ((d - relCyc) / DW) % NP;
      expectLed(d, {idx == 2, idx == 1, 4'(idx)}, (idx == 1 || idx == 2) ? "R10" : "R9");
    end
    repeat (2410) @(negedge clk);
    crs[2] = 1'b0;
    repeat (4) @(negedge clk);

    if (q.size() > 0) begin
      mismatched += q.size();
      $display("FAIL pending: actual %0d unchecked expected 0", q.size());
    end
    summary();
    $finish;
  end

endmodule